// File: doc/BRIEF.md
# Serial Receiver with Ready and Error Requests

This block is the receive half of an asynchronous serial port. It watches a serial input line and finds start bits with a 16x oversampling counter. It then samples eight data bits, an optional parity bit and one stop bit, and places good bytes in a holding register. Two request outputs leave the block. A data-ready request follows the receive-full flag and is meant to start a transfer engine, which clears the flag through an acknowledge input. An error request tells the processor that an overrun, framing or parity fault has been recorded.

A frame with an error never sets receive-full, so the transfer engine stays idle and only the error request rises. Error flags are cleared by software through a small status write port. Reception does not stop while the line is held low (a break), so the framing flag sets again on every frame time. A synchronized copy of the line level is also available to software, so it can recognise a break directly. The baud generator lies outside the block and supplies a tick at sixteen times the bit rate.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, every status flag and both requests are low, and the line readback is high while the line idles high.
- R2: A frame is a low start bit, eight data bits sent LSB first, a parity bit only when `par_en_i` is 1, and a high stop bit. Each bit is taken at oversample count 8 of 16. A frame without error loads `rx_data_o`, sets `rx_full_o` and raises `rxi_req_o`.
- R3: A one-cycle `dma_ack_i` clears `rx_full_o` without any status write.
- R4: With parity enabled, the data bits and the parity bit together must hold an even number of ones when `par_odd_i` is 0, and an odd number when it is 1. On a mismatch `par_err_o` sets, `rx_full_o` stays clear and `rx_data_o` keeps its old value.
- R5: A stop bit sampled low sets `frm_err_o` and leaves `rx_full_o` clear.
- R6: A frame that completes while `rx_full_o` is set sets `ovr_err_o`. `rx_full_o` stays set, and `rx_data_o` keeps the earlier byte.
- R7: `rxi_req_o` equals `rx_full_o`. `eri_req_o` is high exactly while any of the three error flags is set.
- R8: A status write uses bit 0 for receive-full, bit 1 for overrun, bit 2 for framing and bit 3 for parity. A 0 in a bit clears that flag, and a 1 leaves it unchanged.
- R9: While the line is held low, the framing flag sets again on the next frame time after software clears it, and with odd parity the parity flag also sets.
- R10: A low pulse on the line that has ended before the middle of the start bit is ignored.
- R11: `rxd_raw_o` gives the line level after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick at 16x bit rate |
| rxd_i | input | 1 | Serial receive line |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 4 | Status write data; 0 clears the flag |
| dma_ack_i | input | 1 | Transfer engine acknowledge |
| rx_data_o | output | 8 | Received byte |
| rx_full_o | output | 1 | Receive-full flag |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| rxi_req_o | output | 1 | Data-ready request |
| eri_req_o | output | 1 | Error request |
| rxd_raw_o | output | 1 | Synchronized line readback |

## Verification
The bench sends every byte value with even parity, and byte subsets with odd parity and with no parity. It injects parity and stop-bit faults among the good frames. A design that set receive-full on a faulty frame, or that overwrote the held byte, would show a request or a data value that the bench does not expect. A second frame sent before acknowledge checks the overrun path: a wrong design would lose the first byte or drop receive-full. A held-low line checks that the framing flag returns after software clears it, where a receiver that stalled in a break would leave it clear. A short low glitch checks that the start bit is confirmed at mid-bit and not on the falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  localparam int FLG_FULL = 0;
  localparam int FLG_OVR  = 1;
  localparam int FLG_FER  = 2;
  localparam int FLG_PER  = 3;
  localparam int FLG_W    = 4;

  typedef struct packed {
    logic per;
    logic fer;
    logic ovr;
    logic full;
  } flags_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '1;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fer_o,
  output logic              per_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              mid, last;

  assign mid  = tick_i && (cnt == MID_C);
  assign last = tick_i && (cnt == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      fer_o   <= 1'b0;
      per_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state != ST_IDLE && tick_i) cnt <= last ? '0 : cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (tick_i && !rxd_i) begin
          state <= ST_START;
          cnt   <= CNT_W'(1);
        end
        ST_START: begin
          if (mid && rxd_i) state <= ST_IDLE;  // glitch, not a start bit
          else if (last) begin
            state   <= ST_DATA;
            bit_idx <= '0;
          end
        end
        ST_DATA: begin
          if (mid) shreg <= {rxd_i, shreg[DATA_W-1:1]};
          if (last) begin
            if (bit_idx == LAST_BIT) state <= par_en_i ? ST_PAR : ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid)  pbit  <= rxd_i;
          if (last) state <= ST_STOP;
        end
        ST_STOP: if (mid) begin
          done_o <= 1'b1;
          data_o <= shreg;
          fer_o  <= !rxd_i;
          per_o  <= par_en_i && ((^shreg) ^ pbit ^ par_odd_i);
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fer_i,
  input  logic              per_i,
  input  logic              ack_i,
  input  logic              wr_i,
  input  logic [FLG_W-1:0]  wdata_i,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] data_o
);
  flags_t            nxt;
  logic [FLG_W-1:0]  clr;
  logic              good, fresh;

  assign clr   = wr_i ? ~wdata_i : '0;
  assign fresh = done_i && !flags_o.full;
  assign good  = fresh && !fer_i && !per_i;

  always_comb begin
    nxt.full = (flags_o.full && !ack_i && !clr[FLG_FULL]) || good;
    nxt.ovr  = (flags_o.ovr && !clr[FLG_OVR]) || (done_i && flags_o.full);
    nxt.fer  = (flags_o.fer && !clr[FLG_FER]) || (fresh && fer_i);
    nxt.per  = (flags_o.per && !clr[FLG_PER]) || (fresh && per_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      data_o  <= '0;
    end else begin
      flags_o <= nxt;
      if (good) data_o <= data_i;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              sts_wr_i,
  input  logic [3:0]        sts_wdata_i,
  input  logic              dma_ack_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              rxi_req_o,
  output logic              eri_req_o,
  output logic              rxd_raw_o
);
  logic              rxd_s;
  logic              frm_done, frm_fer, frm_per;
  logic [DATA_W-1:0] frm_data;
  flags_t            flags;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_s),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .done_o(frm_done), .data_o(frm_data), .fer_o(frm_fer), .per_o(frm_per)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(frm_done), .data_i(frm_data),
    .fer_i(frm_fer), .per_i(frm_per), .ack_i(dma_ack_i),
    .wr_i(sts_wr_i), .wdata_i(sts_wdata_i),
    .flags_o(flags), .data_o(rx_data_o)
  );

  assign rx_full_o = flags.full;
  assign ovr_err_o = flags.ovr;
  assign frm_err_o = flags.fer;
  assign par_err_o = flags.per;
  assign rxi_req_o = flags.full;
  assign eri_req_o = flags.ovr | flags.fer | flags.per;
  assign rxd_raw_o = rxd_s;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              fer_i,
  input logic              per_i,
  input logic              dma_ack_i,
  input logic              sts_wr_i,
  input logic [3:0]        sts_wdata_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              frm_err_o,
  input logic              eri_req_o
);
  p_full_needs_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_full_o && !done_i) |=> !rx_full_o);

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && dma_ack_i) |=> !rx_full_o);

  p_err_no_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rx_full_o && (fer_i || per_i)) |=> !rx_full_o);

  p_data_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |=> $stable(rx_data_o));

  p_eri_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eri_req_o && !sts_wr_i) |=> eri_req_o);

  p_fer_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && !sts_wdata_i[2] && !done_i) |=> !frm_err_o);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(frm_done), .fer_i(frm_fer),
  .per_i(frm_per), .dma_ack_i(dma_ack_i), .sts_wr_i(sts_wr_i),
  .sts_wdata_i(sts_wdata_i), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
  .frm_err_o(frm_err_o), .eri_req_o(eri_req_o)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  localparam int CLK_P = 10;
  localparam int OS    = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       sts_wr = 1'b0;
  logic [3:0] sts_wdata = 4'hF;
  logic       dma_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, ovr_err, frm_err, par_err, rxi_req, eri_req, rxd_raw;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] e_data = '0;
  logic e_full = 0, e_ovr = 0, e_fer = 0, e_per = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_status dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd),
    .par_en_i(par_en), .par_odd_i(par_odd), .sts_wr_i(sts_wr),
    .sts_wdata_i(sts_wdata), .dma_ack_i(dma_ack), .rx_data_o(rx_data),
    .rx_full_o(rx_full), .ovr_err_o(ovr_err), .frm_err_o(frm_err),
    .par_err_o(par_err), .rxi_req_o(rxi_req), .eri_req_o(eri_req),
    .rxd_raw_o(rxd_raw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk({req, " data"}, rx_data, e_data);
    chk({req, " full"}, rx_full, e_full);
    chk({req, " ovr"},  ovr_err, e_ovr);
    chk({req, " fer"},  frm_err, e_fer);
    chk({req, " per"},  par_err, e_per);
    chk("R7 rxi", rxi_req, e_full);
    chk("R7 eri", eri_req, e_ovr | e_fer | e_per);
  endtask

  task automatic send_bit(input logic b, input int len);
    rxd = b;
    repeat (len) @(negedge clk);
  endtask

  // stop_low: stop bit low for 9 cycles then high, so no new start follows
  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_low);
    logic pb;
    pb = (^d) ^ par_odd ^ flip;
    send_bit(1'b0, OS);
    for (int i = 0; i < 8; i++) send_bit(d[i], OS);
    if (par_en) send_bit(pb, OS);
    if (stop_low) begin
      send_bit(1'b0, 9);
      send_bit(1'b1, OS - 9);
    end else send_bit(1'b1, OS);
    if (e_full) e_ovr = 1;
    else if (stop_low || (par_en && flip)) begin
      e_fer = e_fer | stop_low;
      e_per = e_per | (par_en && flip);
    end else begin
      e_data = d;
      e_full = 1;
    end
  endtask

  task automatic do_ack();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    e_full = 0;
  endtask

  task automatic sw_write(input logic [3:0] w);
    sts_wr = 1'b1;
    sts_wdata = w;
    @(negedge clk);
    sts_wr = 1'b0;
    sts_wdata = 4'hF;
    if (!w[0]) e_full = 0;
    if (!w[1]) e_ovr = 0;
    if (!w[2]) e_fer = 0;
    if (!w[3]) e_per = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    cmp_all("R1");
    chk("R1 raw", rxd_raw, 1'b1);

    // R2 R3 R4: every byte, even parity, drained by acknowledge
    par_en = 1; par_odd = 0;
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b0, 1'b0);
      cmp_all("R2");
      do_ack();
      chk("R3 ack", rx_full, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R4: odd parity with injected parity faults
    par_odd = 1;
    for (int v = 0; v < 64; v++) begin
      logic flip;
      flip = (v % 3 == 0);
      send_frame(8'(v * 4 + 3), flip, 1'b0);
      cmp_all("R4");
      if (flip) begin
        sw_write(4'b1111);
        chk("R8 write1", par_err, 1'b1);
        sw_write(4'b0111);
        chk("R8 clr per", par_err, 1'b0);
      end else do_ack();
      repeat (2) @(negedge clk);
    end

    // R5: no parity with stop-bit faults
    par_en = 0;
    for (int v = 0; v < 64; v++) begin
      logic bad;
      bad = (v % 5 == 2);
      send_frame(8'(v * 4 + 1), 1'b0, bad);
      cmp_all("R5");
      if (bad) begin
        sw_write(4'b1011);
        chk("R8 clr fer", frm_err, 1'b0);
      end else do_ack();
      repeat (2) @(negedge clk);
    end

    // R6: overrun keeps first byte
    send_frame(8'hA5, 1'b0, 1'b0);
    send_frame(8'h3C, 1'b0, 1'b0);
    cmp_all("R6");
    chk("R6 data", rx_data, 8'hA5);
    sw_write(4'b1101);
    cmp_all("R8 clr ovr");
    sw_write(4'b1110);
    cmp_all("R8 clr full");

    // R10: short glitch
    send_bit(1'b0, 5);
    send_bit(1'b1, 200);
    cmp_all("R10");

    // R9 R11: break with odd parity
    par_en = 1; par_odd = 1;
    rxd = 1'b0;
    repeat (190) @(negedge clk);
    chk("R11 raw", rxd_raw, 1'b0);
    chk("R9 fer", frm_err, 1'b1);
    chk("R9 per", par_err, 1'b1);
    chk("R9 full", rx_full, 1'b0);
    chk("R7 eri", eri_req, 1'b1);
    sw_write(4'b0011);
    chk("R8 clr brk", frm_err, 1'b0);
    chk("R7 eri low", eri_req, 1'b0);
    repeat (190) @(negedge clk);
    chk("R9 fer again", frm_err, 1'b1);
    chk("R9 full again", rx_full, 1'b0);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R11 raw high", rxd_raw, 1'b1);
    sw_write(4'b0000);
    e_data = rx_data;
    cmp_all("R8 clr all");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule